// File: doc/BRIEF.md
# DRAM Row/Column Address Multiplexer with CAS-before-RAS Refresh Mode

This block sits between a word-addressed requester and a page-mode DRAM. It takes a 20-bit word address and splits it into a row half and a column half. It puts those halves in turn onto a 10-bit multiplexed address bus and generates the RAS, CAS and WE strobes. Each accepted request becomes one DRAM cycle. A read or write cycle runs RAS first, then the column, then CAS. When the configuration says so, the cycle is instead a CAS-before-RAS refresh. Refresh mode is what a DRAM needs for its first few accesses after power-up. Boot code switches to normal cycles once that is done.

Two DRAM organisations are supported. Deep parts (1M words) use the plain row mapping. Shallow parts (256K words) have a 512-word page, so one row pin takes a different address bit. The requester raises `req` while the block is idle and holds it until `ack` pulses. Read data is presented alongside the acknowledge and stays until the next read.

Top module: `dram_addr_mux`

## Requirements
- R1: During and right after synchronous reset, `ras_n`, `cas_n` and `we_n` are 1, while `ack`, `dq_oe`, `dq_out`, `dram_a` and `rdata` are 0.
- R2: A normal cycle starts with the request sampled while idle. Counting clocks from that edge, RAS is low in clocks 1 to 4, and CAS is low in clocks 3 and 4 (CAS_CLKS=2). Both strobes are high in the two precharge clocks 5 and 6 (PRE_CLKS=2). The block is idle again in clock 7.
- R3: With `cfg_page512`=0, `dram_a` in clock 1 equals address bits 19..10, with pin 9 carrying bit 19.
- R4: With `cfg_page512`=1, `dram_a[8]` carries address bit 9 in clock 1. All other row pins are unchanged from R3.
- R5: In clocks 2 to 4, `dram_a` equals address bits 9..0.
- R6: On a write, `we_n` is 0 and `dq_oe` is 1 in clocks 2 to 4, and `dq_out` equals the write data in those clocks. Outside those clocks, and on every read, `we_n` is 1, `dq_oe` is 0 and `dq_out` is 0.
- R7: On a read, `dq_in` is captured at the end of the last CAS clock. It appears on `rdata` in clock 5, together with an `ack` pulse exactly one clock long, and is held until the next read. Writes also pulse `ack` in clock 5 and leave `rdata` unchanged.
- R8: With `cfg_normal`=0, an access is a refresh. CAS is low in clocks 1 to 3 and RAS is low in clocks 2 and 3. `we_n` stays 1, `ack` pulses in clock 4, clocks 4 and 5 are precharge, and `rdata` is unchanged.
- R9: During a refresh, `dram_a` carries a 10-bit refresh row. It is 0 after reset, rises by one after each refresh cycle and wraps from 1023 to 0, so consecutive refreshes present different row values.
- R10: `cfg_normal` and `cfg_page512` are sampled only on the clock that accepts a request. Changing them during a cycle has no effect on that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_normal | input | 1 | 1 = normal read/write cycles, 0 = every access is a refresh |
| cfg_page512 | input | 1 | 1 = 256K part with 512-word page (row pin 8 takes address bit 9) |
| req | input | 1 | Access request, held until ack |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | 20 | Word address |
| wdata | input | 20 | Write data |
| ack | output | 1 | One-clock completion pulse |
| rdata | output | 20 | Read data, valid with ack on reads |
| dram_a | output | 10 | Multiplexed row/column address pins |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| dq_out | output | 20 | Data driven toward the DRAM |
| dq_oe | output | 1 | Output enable for dq_out |
| dq_in | input | 20 | Data returned from the DRAM |

## Verification
The bench walks a single 1 through every address bit under both page settings, as both read and write, and compares every pin on every clock of each cycle. A swapped or missing pin-8 remap, or a row/column mix-up, therefore shows up as a wrong bit on `dram_a` in the row or column clock. It then runs more than 1024 refresh cycles in a row. A refresh counter that does not advance, advances twice or fails to wrap gives a repeated or skipped row value. A strobe order that lets RAS lead CAS during refresh shows up on the first refresh clock. Finally, the bench flips both configuration inputs in the middle of cycles. A design that reads its configuration live rather than once at acceptance changes cycle type or row mapping partway through, and the per-clock comparison catches it.

// File: rtl/dmx_pkg.sv
package dmx_pkg;

    localparam int ADDR_W = 20;
    localparam int PIN_W  = 10;
    localparam int DATA_W = 20;
    localparam int HIGH_BIT = ADDR_W - 1;          // row pin PIN_W-1 source
    localparam int ALT_BIT  = ADDR_W - PIN_W - 1;  // bit moved onto row pin 8

    typedef enum logic [2:0] {
        S_IDLE,
        S_ROW,
        S_COL,
        S_CAS,
        S_PRE,
        S_RCAS,
        S_RBOTH
    } phase_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic              wr;
        logic              page512;
    } job_t;

    function automatic logic [PIN_W-1:0] row_of(input logic [ADDR_W-1:0] a,
                                                  input logic page512);
        logic [PIN_W-1:0] r;
        r = a[ADDR_W-1 -: PIN_W];
        if (page512) r[PIN_W-2] = a[ALT_BIT];
        return r;
    endfunction

    function automatic logic [PIN_W-1:0] col_of(input logic [ADDR_W-1:0] a);
        return a[PIN_W-1:0];
    endfunction

endpackage

// File: rtl/dmx_rowmap.sv
module dmx_rowmap
    import dmx_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              page512,
    output logic [PIN_W-1:0]  row,
    output logic [PIN_W-1:0]  col
);
    always_comb begin
        row = row_of(addr, page512);
        col = col_of(addr);
    end
endmodule

// File: rtl/dmx_refcnt.sv
module dmx_refcnt
    import dmx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    output logic [PIN_W-1:0] count
);
    always_ff @(posedge clk) begin
        if (rst)       count <= '0;
        else if (step) count <= count + 1'b1;
    end

    // R9
    refrow_step_chk: assert property (@(posedge clk) disable iff (rst)
        step |=> count == $past(count) + 1'b1);
endmodule

// File: rtl/dmx_seq.sv
module dmx_seq
    import dmx_pkg::*;
#(
    parameter int CAS_CLKS = 2,
    parameter int PRE_CLKS = 2,
    parameter int REF_CLKS = 2
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic              wr,
    input  logic              cfg_normal,
    input  logic              cfg_page512,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] dq_in,
    output phase_e            phase,
    output job_t              job,
    output logic              ack,
    output logic [DATA_W-1:0] rdata,
    output logic              ref_done
);
    localparam int MAXC = (CAS_CLKS > PRE_CLKS) ?
                          ((CAS_CLKS > REF_CLKS) ? CAS_CLKS : REF_CLKS) :
                          ((PRE_CLKS > REF_CLKS) ? PRE_CLKS : REF_CLKS);
    localparam int CW = $clog2(MAXC + 1);
    localparam logic [CW-1:0] CAS_LAST = CW'(CAS_CLKS - 1);
    localparam logic [CW-1:0] PRE_LAST = CW'(PRE_CLKS - 1);
    localparam logic [CW-1:0] REF_LAST = CW'(REF_CLKS - 1);

    logic [CW-1:0] cnt;

    assign ref_done = (phase == S_RBOTH) && (cnt == REF_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= S_IDLE;
            cnt   <= '0;
            ack   <= 1'b0;
            rdata <= '0;
            job   <= '0;
        end else begin
            ack <= 1'b0;
            case (phase)
                S_IDLE: if (req) begin
                    job.addr    <= addr;
                    job.wdata   <= wdata;
                    job.wr      <= wr;
                    job.page512 <= cfg_page512;
                    phase       <= cfg_normal ? S_ROW : S_RCAS;
                    cnt         <= '0;
                end
                S_ROW:  phase <= S_COL;
                S_COL: begin
                    phase <= S_CAS;
                    cnt   <= '0;
                end
                S_CAS: if (cnt == CAS_LAST) begin
                    phase <= S_PRE;
                    cnt   <= '0;
                    ack   <= 1'b1;
                    if (!job.wr) rdata <= dq_in;
                end else begin
                    cnt <= cnt + 1'b1;
                end
                S_PRE: if (cnt == PRE_LAST) begin
                    phase <= S_IDLE;
                    cnt   <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
                S_RCAS: begin
                    phase <= S_RBOTH;
                    cnt   <= '0;
                end
                S_RBOTH: if (cnt == REF_LAST) begin
                    phase <= S_PRE;
                    cnt   <= '0;
                    ack   <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
                default: phase <= S_IDLE;
            endcase
        end
    end

    // R7
    ack_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        ack |=> !ack);
    // R7
    ack_into_pre_chk: assert property (@(posedge clk) disable iff (rst)
        ack |-> phase == S_PRE);
endmodule

// File: rtl/dram_addr_mux.sv
module dram_addr_mux
    import dmx_pkg::*;
#(
    parameter int CAS_CLKS = 2,
    parameter int PRE_CLKS = 2,
    parameter int REF_CLKS = 2
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_normal,
    input  logic              cfg_page512,
    input  logic              req,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              ack,
    output logic [DATA_W-1:0] rdata,
    output logic [PIN_W-1:0]  dram_a,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe,
    input  logic [DATA_W-1:0] dq_in
);
    phase_e           phase;
    job_t             job;
    logic             ref_done;
    logic [PIN_W-1:0] row, col, refrow;
    logic             drive_wr;

    dmx_seq #(
        .CAS_CLKS(CAS_CLKS),
        .PRE_CLKS(PRE_CLKS),
        .REF_CLKS(REF_CLKS)
    ) u_seq (
        .clk(clk), .rst(rst), .req(req), .wr(wr),
        .cfg_normal(cfg_normal), .cfg_page512(cfg_page512),
        .addr(addr), .wdata(wdata), .dq_in(dq_in),
        .phase(phase), .job(job), .ack(ack), .rdata(rdata),
        .ref_done(ref_done)
    );

    dmx_rowmap u_map (
        .addr(job.addr), .page512(job.page512), .row(row), .col(col)
    );

    dmx_refcnt u_ref (
        .clk(clk), .rst(rst), .step(ref_done), .count(refrow)
    );

    always_comb begin
        drive_wr = job.wr && (phase == S_COL || phase == S_CAS);
        ras_n    = !(phase == S_ROW || phase == S_COL ||
                     phase == S_CAS || phase == S_RBOTH);
        cas_n    = !(phase == S_CAS || phase == S_RCAS || phase == S_RBOTH);
        we_n     = !drive_wr;
        dq_oe    = drive_wr;
        dq_out   = drive_wr ? job.wdata : '0;
        case (phase)
            S_ROW:          dram_a = row;
            S_COL, S_CAS:   dram_a = col;
            S_RCAS,S_RBOTH: dram_a = refrow;
            default:        dram_a = '0;
        endcase
    end

    // R2
    precharge_min_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ras_n) |=> ras_n);
    // R6
    we_inside_ras_chk: assert property (@(posedge clk) disable iff (rst)
        !we_n |-> !ras_n);
    // R8
    cbr_order_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(cas_n) && ras_n) |=> !ras_n);
    // R2
    ras_before_cas_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(cas_n) && !ras_n) |-> $past(!ras_n));
    // R8
    refresh_no_write_chk: assert property (@(posedge clk) disable iff (rst)
        (!cas_n && ras_n) |-> we_n);
endmodule

// File: tb/test_dram_addr_mux.sv
module test_dram_addr_mux;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_normal = 1'b1, cfg_page512 = 1'b0;
    logic        req = 1'b0, wr = 1'b0;
    logic [19:0] addr = '0, wdata = '0, dq_in = '0;
    logic        ack, ras_n, cas_n, we_n, dq_oe;
    logic [19:0] rdata, dq_out;
    logic [9:0]  dram_a;

    int vectors = 0;
    int errors  = 0;
    logic [19:0] exp_rdata = '0;
    logic [9:0]  exp_ref   = '0;

    always #4 clk = ~clk;

    dram_addr_mux i_dram_addr_mux (
        .clk(clk), .rst(rst), .cfg_normal(cfg_normal), .cfg_page512(cfg_page512),
        .req(req), .wr(wr), .addr(addr), .wdata(wdata), .ack(ack), .rdata(rdata),
        .dram_a(dram_a), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in)
    );

    task automatic cmp(input string tag, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // Normal cycle; clock k counted from the accepting edge.
    task automatic normal_access(input logic page, input logic w, input logic [19:0] a,
                                 input logic [19:0] wd, input logic [19:0] din,
                                 input bit flip, input string tag);
        logic [9:0] row, col;
        row = a[19:10];
        if (page) row[8] = a[9];
        col = a[9:0];
        cfg_normal = 1'b1; cfg_page512 = page;
        req = 1'b1; wr = w; addr = a; wdata = wd; dq_in = din;
        for (int k = 1; k <= 7; k++) begin
            logic er, ec, ew, ea;
            logic [9:0]  eaddr;
            logic [19:0] ed;
            @(negedge clk);
            req = 1'b0;
            if (flip && k == 2) begin cfg_normal = 1'b0; cfg_page512 = ~page; end
            er = !(k >= 1 && k <= 4);
            ec = !(k == 3 || k == 4);
            ew = !(w && k >= 2 && k <= 4);
            ea = (k == 5);
            eaddr = (k == 1) ? row : (k >= 2 && k <= 4) ? col : 10'd0;
            ed = (!ew) ? wd : 20'd0;
            if (k == 5 && !w) exp_rdata = din;
            cmp(tag, {ras_n, cas_n, we_n, dq_oe, ack, dram_a, dq_out},
                     {er, ec, ew, !ew, ea, eaddr, ed});
            if (k == 5 || k == 7) cmp("R7 rdata", {44'd0, rdata}, {44'd0, exp_rdata});
        end
        cfg_normal = 1'b1; cfg_page512 = page;
    endtask

    task automatic refresh_access(input logic [19:0] a, input bit flip, input string tag);
        cfg_normal = 1'b0;
        req = 1'b1; wr = 1'b1; addr = a; wdata = ~a; dq_in = a ^ 20'h5A5A5;
        for (int k = 1; k <= 6; k++) begin
            logic er, ec, ea;
            logic [9:0] eaddr;
            @(negedge clk);
            req = 1'b0;
            if (flip && k == 2) cfg_normal = 1'b1;
            ec = !(k >= 1 && k <= 3);
            er = !(k == 2 || k == 3);
            ea = (k == 4);
            eaddr = (k <= 3) ? exp_ref : 10'd0;
            cmp(tag, {ras_n, cas_n, we_n, dq_oe, ack, dram_a, dq_out},
                     {er, ec, 1'b1, 1'b0, ea, eaddr, 20'd0});
            if (k == 4) cmp("R8 rdata held", {44'd0, rdata}, {44'd0, exp_rdata});
        end
        exp_ref = exp_ref + 1'b1;
        cfg_normal = 1'b0;
    endtask

    initial begin
        #800000;
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        logic [19:0] lfsr;
        repeat (3) @(negedge clk);
        // R1 reset state
        cmp("R1 reset", {ras_n, cas_n, we_n, dq_oe, ack, dram_a, dq_out, rdata},
                        {5'b11100, 10'd0, 20'd0, 20'd0});
        rst = 1'b0;
        @(negedge clk);
        cmp("R1 after reset", {ras_n, cas_n, we_n, dq_oe, ack, dram_a, dq_out, rdata},
                              {5'b11100, 10'd0, 20'd0, 20'd0});
        // R3 R4 R5 R6 walking-one sweep under both page settings
        for (int p = 0; p < 2; p++)
            for (int b = 0; b < 20; b++)
                for (int w = 0; w < 2; w++)
                    normal_access(p[0], w[0], 20'd1 << b, 20'hFFFFF ^ (20'd1 << b),
                                  20'h12345 + 20'(b * 977 + p * 31),
                                  1'b0, "R2 R3 R4 R5 R6 walk");
        lfsr = 20'hACE1B;
        for (int n = 0; n < 60; n++) begin
            lfsr = {lfsr[18:0], lfsr[19] ^ lfsr[16]};
            normal_access(lfsr[3], lfsr[0], lfsr, ~lfsr, lfsr ^ 20'h0F0F0,
                          1'b0, "R2 R3 R4 R5 R6 R7 mixed");
        end
        // R8 R9 refresh run across the counter wrap
        for (int n = 0; n < 1030; n++)
            refresh_access(20'(n * 613), 1'b0, "R8 R9 refresh");
        // R10 configuration changed mid-cycle
        refresh_access(20'h3C3C3, 1'b1, "R10 refresh flip");
        normal_access(1'b1, 1'b0, 20'hF83FF, 20'h0, 20'hBEEF1, 1'b1, "R10 read flip");
        normal_access(1'b0, 1'b1, 20'h07E00, 20'h55AA5, 20'h0, 1'b1, "R10 write flip");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule